// File: doc/BRIEF.md
# Debug breakpoint trap unit

This unit sits beside a small microcontroller core with a 13-bit program counter. It decides when execution must leave the user program and enter a debug kernel held in the top 256 words of an 8K-word program space. Three events can trigger it: a retired instruction whose address equals a programmable breakpoint, the completion of a single step that the host requested, or a halt command from the host. A halt command arrives on an unsynchronised line.

When any trigger is taken, the unit raises a one-cycle, non-maskable trap request. It presents the fixed kernel vector and the return address that the core pushes onto its hardware stack. It also reports the cause in a one-hot field. The unit raises no further trap until the kernel signals its return. The breakpoint comes out of reset pointing at address zero. As a result, the first instruction after reset, which must be a filler, is followed at once by entry into the kernel.

Top module: `dbg_trap_unit`

## Requirements
- R1: After reset the breakpoint reads as 0x0000, `trap_req` is 0 and `trap_cause` is 0. The first retirement of PC 0x0000 with debug enabled traps with the breakpoint cause.
- R2: When debug is enabled, a write to data address 0x18E loads breakpoint bits 12:8 from `reg_wr_data[4:0]`, and a write to 0x18F loads bits 7:0. A read of 0x18E returns zeros in bits 7:5. A read of any other address returns 0. A write to any other address changes neither register.
- R3: While `dbg_en` is 0, writes to both breakpoint registers are ignored.
- R4: A retirement (`retire_vld`=1) whose PC equals the breakpoint makes `trap_req` high for exactly the next cycle. In that cycle `trap_vec` is 0x1F00 and `trap_ret_pc` is the retired PC plus one. A matching PC with `retire_vld`=0 does not trap.
- R5: A `step_req` pulse accepted while in the kernel arms the unit. After `kernel_ret`, exactly the next retirement traps with the step cause, and the retirement after that does not. A `step_req` outside the kernel is ignored.
- R6: A rising edge on `halt_req` passes through a two-flop synchroniser and makes the next retirement trap with the halt cause. A halt that rises while in the kernel is discarded.
- R7: No trap is raised while the unit is in the kernel, or for any retired PC in 0x1F00–0x1FFF, even when it matches the breakpoint.
- R8: `trap_cause` is one-hot: bit 0 is breakpoint, bit 1 is step, bit 2 is halt. The priority is breakpoint, then step, then halt. Causes that coincide with the one reported are consumed.
- R9: `trap_cause` holds its value until `kernel_ret` and is then cleared.
- R10: While `dbg_en` is 0, no trap is raised and step and halt requests are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_en | input | 1 | Debug mode enable |
| retire_vld | input | 1 | One instruction retired this cycle |
| retire_pc | input | 13 | Address of the retired instruction |
| reg_wr_en | input | 1 | Data-space write strobe |
| reg_wr_addr | input | 9 | Data-space write address |
| reg_wr_data | input | 8 | Data-space write value |
| reg_rd_addr | input | 9 | Data-space read address |
| reg_rd_data | output | 8 | Breakpoint register read value |
| step_req | input | 1 | Host single-step request pulse |
| halt_req | input | 1 | Asynchronous host halt line |
| kernel_ret | input | 1 | Kernel return pulse |
| trap_req | output | 1 | One-cycle trap request |
| trap_vec | output | 13 | Kernel entry address |
| trap_ret_pc | output | 13 | Return address to push |
| trap_cause | output | 3 | One-hot trap cause |

## Verification
Two triggers can fall on the same retirement: an armed single step, or a pending halt, can coincide with a breakpoint match or with each other. The bench provokes this in two ways. It arms a step and then retires the breakpoint address. It also arms a step and then posts a halt before the next retirement. Each case is judged on two points: the reported cause must be the higher-priority one, and the following retirement must raise no second trap, which shows the losing request was consumed.

// File: rtl/dbg_trap_pkg.sv
`timescale 1ns/1ps
package dbg_trap_pkg;
  localparam int PC_W    = 13;
  localparam int DAT_W   = 8;
  localparam int RA_W    = 9;
  localparam int KSPAN_W = 8;
  localparam logic [PC_W-1:0] KERNEL_BASE = 13'h1F00;

  typedef struct packed {
    logic halt;
    logic step;
    logic bp;
  } cause_t;

  function automatic logic [PC_W-1:0] pc_after(input logic [PC_W-1:0] pc);
    return pc + 13'd1;
  endfunction

  function automatic logic in_kernel_area(input logic [PC_W-1:0] pc);
    return pc[PC_W-1:KSPAN_W] == KERNEL_BASE[PC_W-1:KSPAN_W];
  endfunction

  function automatic cause_t pick_cause(input logic bp, input logic st, input logic ht);
    cause_t c;
    c = '0;
    if (bp)      c.bp   = 1'b1;
    else if (st) c.step = 1'b1;
    else if (ht) c.halt = 1'b1;
    return c;
  endfunction
endpackage

// File: rtl/dbg_bp_regfile.sv
`timescale 1ns/1ps
module dbg_bp_regfile
  import dbg_trap_pkg::*;
#(
  parameter logic [RA_W-1:0] HI_ADDR   = 9'h18E,
  parameter logic [RA_W-1:0] LO_ADDR   = 9'h18F,
  parameter logic [PC_W-1:0] RESET_VEC = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dbg_en,
  input  logic             wr_en,
  input  logic [RA_W-1:0]  wr_addr,
  input  logic [DAT_W-1:0] wr_data,
  input  logic [RA_W-1:0]  rd_addr,
  output logic [DAT_W-1:0] rd_data,
  output logic [PC_W-1:0]  bp_addr
);
  localparam int HI_W = PC_W - DAT_W;

  logic [HI_W-1:0]  hi_q;
  logic [DAT_W-1:0] lo_q;
  logic             wr_hi, wr_lo;
  logic             unused_hi_bits;

  assign wr_hi = dbg_en && wr_en && (wr_addr == HI_ADDR);
  assign wr_lo = dbg_en && wr_en && (wr_addr == LO_ADDR);
  assign unused_hi_bits = &{1'b0, wr_data[DAT_W-1:HI_W]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= RESET_VEC[PC_W-1:DAT_W];
      lo_q <= RESET_VEC[DAT_W-1:0];
    end else begin
      if (wr_hi) hi_q <= wr_data[HI_W-1:0];
      if (wr_lo) lo_q <= wr_data;
    end
  end

  assign bp_addr = {hi_q, lo_q};

  always_comb begin
    if (rd_addr == HI_ADDR)      rd_data = {{(DAT_W-HI_W){1'b0}}, hi_q};
    else if (rd_addr == LO_ADDR) rd_data = lo_q;
    else                         rd_data = '0;
  end

  AST_BP_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !dbg_en |=> $stable(bp_addr)); // R3
  AST_FOREIGN_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_addr != HI_ADDR && wr_addr != LO_ADDR) |=> $stable(bp_addr)); // R2
endmodule

// File: rtl/dbg_halt_sync.sv
`timescale 1ns/1ps
module dbg_halt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  localparam int SW = (STAGES < 2) ? 2 : STAGES;

  logic [SW-1:0] sh;
  logic          last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh     <= '0;
      last_q <= 1'b0;
    end else begin
      sh     <= {sh[SW-2:0], async_in};
      last_q <= sh[SW-1];
    end
  end

  assign rise = sh[SW-1] & ~last_q;

  AST_RISE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise); // R6
endmodule

// File: rtl/dbg_trap_ctrl.sv
`timescale 1ns/1ps
module dbg_trap_ctrl
  import dbg_trap_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dbg_en,
  input  logic            retire_vld,
  input  logic [PC_W-1:0] retire_pc,
  input  logic [PC_W-1:0] bp_addr,
  input  logic            step_req,
  input  logic            halt_rise,
  input  logic            kernel_ret,
  output logic            trap_req,
  output logic [2:0]      trap_cause,
  output logic [PC_W-1:0] trap_ret_pc,
  output logic            in_kernel
);
  logic   eligible, hit_bp, hit_step, hit_halt, fire, leave;
  logic   step_pend, step_armed, halt_pend, trap_q;
  cause_t cause_q;
  logic [PC_W-1:0] ret_q;

  assign eligible = dbg_en && retire_vld && !in_kernel && !in_kernel_area(retire_pc);
  assign hit_bp   = eligible && (retire_pc == bp_addr);
  assign hit_step = eligible && step_armed;
  assign hit_halt = eligible && halt_pend;
  assign fire     = hit_bp || hit_step || hit_halt;
  assign leave    = kernel_ret && in_kernel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_q     <= 1'b0;
      in_kernel  <= 1'b0;
      cause_q    <= '0;
      ret_q      <= '0;
      step_pend  <= 1'b0;
      step_armed <= 1'b0;
      halt_pend  <= 1'b0;
    end else begin
      trap_q <= fire;
      if (fire) begin
        in_kernel  <= 1'b1;
        cause_q    <= pick_cause(hit_bp, hit_step, hit_halt);
        ret_q      <= pc_after(retire_pc);
        step_armed <= 1'b0;
        halt_pend  <= 1'b0;
      end else begin
        if (leave) begin
          in_kernel  <= 1'b0;
          cause_q    <= '0;
          step_armed <= step_pend;
        end
        if (dbg_en && !in_kernel && halt_rise) halt_pend <= 1'b1;
      end
      if (leave)                                step_pend <= 1'b0;
      else if (dbg_en && in_kernel && step_req) step_pend <= 1'b1;
    end
  end

  assign trap_req    = trap_q;
  assign trap_cause  = cause_q;
  assign trap_ret_pc = ret_q;

  AST_TRAP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |=> !trap_req); // R4
  AST_CAUSE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> ($countones(trap_cause) == 1)); // R8
  AST_KERNEL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_vld && in_kernel_area(retire_pc)) |=> !trap_req); // R7
  AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !dbg_en |=> !trap_req); // R10
  AST_CAUSE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_kernel && !kernel_ret) |=> $stable(trap_cause)); // R9
  AST_RET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_kernel && kernel_ret) |=> (trap_cause == 3'b000)); // R9
  AST_STEP_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && trap_cause[1]) |-> !step_armed); // R5
endmodule

// File: rtl/dbg_trap_unit.sv
`timescale 1ns/1ps
module dbg_trap_unit
  import dbg_trap_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        dbg_en,
  input  logic        retire_vld,
  input  logic [12:0] retire_pc,
  input  logic        reg_wr_en,
  input  logic [8:0]  reg_wr_addr,
  input  logic [7:0]  reg_wr_data,
  input  logic [8:0]  reg_rd_addr,
  output logic [7:0]  reg_rd_data,
  input  logic        step_req,
  input  logic        halt_req,
  input  logic        kernel_ret,
  output logic        trap_req,
  output logic [12:0] trap_vec,
  output logic [12:0] trap_ret_pc,
  output logic [2:0]  trap_cause
);
  logic [PC_W-1:0] bp_addr;
  logic            halt_rise;
  logic            in_kernel;

  dbg_bp_regfile u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .dbg_en  (dbg_en),
    .wr_en   (reg_wr_en),
    .wr_addr (reg_wr_addr),
    .wr_data (reg_wr_data),
    .rd_addr (reg_rd_addr),
    .rd_data (reg_rd_data),
    .bp_addr (bp_addr)
  );

  dbg_halt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (halt_req),
    .rise     (halt_rise)
  );

  dbg_trap_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .dbg_en      (dbg_en),
    .retire_vld  (retire_vld),
    .retire_pc   (retire_pc),
    .bp_addr     (bp_addr),
    .step_req    (step_req),
    .halt_rise   (halt_rise),
    .kernel_ret  (kernel_ret),
    .trap_req    (trap_req),
    .trap_cause  (trap_cause),
    .trap_ret_pc (trap_ret_pc),
    .in_kernel   (in_kernel)
  );

  assign trap_vec = KERNEL_BASE;

  AST_RET_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> (trap_ret_pc == $past(retire_pc) + 13'd1)); // R4
  AST_RET_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_kernel && !trap_req) |=> $stable(trap_ret_pc)); // R4
endmodule

// File: tb/sim_dbg_trap_unit.sv
`timescale 1ns/1ps
module sim_dbg_trap_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dbg_en = 1'b1;
  logic        retire_vld = 1'b0;
  logic [12:0] retire_pc = '0;
  logic        reg_wr_en = 1'b0;
  logic [8:0]  reg_wr_addr = '0;
  logic [7:0]  reg_wr_data = '0;
  logic [8:0]  reg_rd_addr = '0;
  logic [7:0]  reg_rd_data;
  logic        step_req = 1'b0;
  logic        halt_req = 1'b0;
  logic        kernel_ret = 1'b0;
  logic        trap_req;
  logic [12:0] trap_vec;
  logic [12:0] trap_ret_pc;
  logic [2:0]  trap_cause;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  localparam logic [2:0] C_BP = 3'b001, C_ST = 3'b010, C_HT = 3'b100;

  always #5 clk = ~clk;

  dbg_trap_unit u0 (
    .clk(clk), .rst_n(rst_n), .dbg_en(dbg_en), .retire_vld(retire_vld),
    .retire_pc(retire_pc), .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
    .reg_wr_data(reg_wr_data), .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
    .step_req(step_req), .halt_req(halt_req), .kernel_ret(kernel_ret),
    .trap_req(trap_req), .trap_vec(trap_vec), .trap_ret_pc(trap_ret_pc),
    .trap_cause(trap_cause)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic retire(input logic [12:0] pc, input logic vld);
    retire_pc = pc; retire_vld = vld;
    @(negedge clk);
    retire_vld = 1'b0;
  endtask

  task automatic wr(input logic [8:0] a, input logic [7:0] d);
    reg_wr_addr = a; reg_wr_data = d; reg_wr_en = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0; reg_wr_addr = '0;
  endtask

  task automatic rd_chk(input string req, input logic [8:0] a, input logic [7:0] exp);
    reg_rd_addr = a;
    #1;
    chk(req, reg_rd_data, exp);
  endtask

  task automatic kret();
    kernel_ret = 1'b1;
    @(negedge clk);
    kernel_ret = 1'b0;
  endtask

  task automatic step_pulse();
    step_req = 1'b1;
    @(negedge clk);
    step_req = 1'b0;
  endtask

  task automatic halt_pulse();
    halt_req = 1'b1;
    repeat (4) @(negedge clk);
    halt_req = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 trap_req in reset", trap_req, 0);
    chk("R1 cause in reset", trap_cause, 0);
    @(negedge clk); rst_n = 1'b1;
    rd_chk("R1 bp high after reset", 9'h18E, 8'h00);
    rd_chk("R1 bp low after reset", 9'h18F, 8'h00);
    retire(13'h0000, 1'b1);
    chk("R1 first retire traps", trap_req, 1);
    chk("R1 cause bp", trap_cause, C_BP);
    chk("R4 vector", trap_vec, 13'h1F00);
    chk("R4 return pc", trap_ret_pc, 13'h0001);
    @(negedge clk);
    chk("R4 single pulse", trap_req, 0);
    chk("R9 cause held", trap_cause, C_BP);
    kret();
    chk("R9 cause cleared", trap_cause, 0);
  endtask

  task automatic t_regs();
    wr(9'h18E, 8'hFF);
    rd_chk("R2 high unused bits zero", 9'h18E, 8'h1F);
    wr(9'h18F, 8'h34);
    rd_chk("R2 low write", 9'h18F, 8'h34);
    wr(9'h18E, 8'h01);
    wr(9'h18F, 8'h23);
    wr(9'h18D, 8'h55);
    rd_chk("R2 foreign write high", 9'h18E, 8'h01);
    rd_chk("R2 foreign write low", 9'h18F, 8'h23);
    rd_chk("R2 foreign read", 9'h18D, 8'h00);
  endtask

  task automatic t_bp_hit();
    retire(13'h0122, 1'b1);
    chk("R4 no trap on miss", trap_req, 0);
    retire(13'h0123, 1'b0);
    chk("R4 no trap without retire", trap_req, 0);
    retire(13'h0123, 1'b1);
    chk("R4 bp trap", trap_req, 1);
    chk("R4 bp cause", trap_cause, C_BP);
    chk("R4 bp return pc", trap_ret_pc, 13'h0124);
    retire(13'h0123, 1'b1);
    chk("R7 no trap in kernel", trap_req, 0);
    kret();
  endtask

  task automatic t_kernel_area();
    wr(9'h18E, 8'h1F);
    wr(9'h18F, 8'h05);
    retire(13'h1F05, 1'b1);
    chk("R7 kernel area bp ignored", trap_req, 0);
    chk("R7 kernel area cause", trap_cause, 0);
    wr(9'h18E, 8'h01);
    wr(9'h18F, 8'h23);
  endtask

  task automatic t_disabled();
    dbg_en = 1'b0;
    wr(9'h18F, 8'h77);
    rd_chk("R3 write ignored when disabled", 9'h18F, 8'h23);
    retire(13'h0123, 1'b1);
    chk("R10 no trap when disabled", trap_req, 0);
    halt_pulse();
    dbg_en = 1'b1;
    retire(13'h0050, 1'b1);
    chk("R10 halt dropped when disabled", trap_req, 0);
  endtask

  task automatic t_step();
    step_pulse();
    retire(13'h0126, 1'b1);
    chk("R5 step outside kernel ignored", trap_req, 0);
    retire(13'h0123, 1'b1);
    step_pulse();
    kret();
    retire(13'h0124, 1'b1);
    chk("R5 step trap", trap_req, 1);
    chk("R5 step cause", trap_cause, C_ST);
    chk("R5 step return pc", trap_ret_pc, 13'h0125);
    kret();
    retire(13'h0125, 1'b1);
    chk("R5 step disarmed", trap_req, 0);
  endtask

  task automatic t_halt();
    halt_pulse();
    chk("R6 no trap without retire", trap_req, 0);
    retire(13'h0200, 1'b1);
    chk("R6 halt trap", trap_req, 1);
    chk("R6 halt cause", trap_cause, C_HT);
    kret();
    retire(13'h0123, 1'b1);
    halt_pulse();
    kret();
    retire(13'h0300, 1'b1);
    chk("R6 halt in kernel discarded", trap_req, 0);
  endtask

  task automatic t_coincide();
    retire(13'h0123, 1'b1);
    step_pulse();
    kret();
    retire(13'h0123, 1'b1);
    chk("R8 bp beats step", trap_cause, C_BP);
    kret();
    retire(13'h0124, 1'b1);
    chk("R8 step consumed", trap_req, 0);
    retire(13'h0123, 1'b1);
    step_pulse();
    kret();
    halt_pulse();
    retire(13'h0400, 1'b1);
    chk("R8 step beats halt", trap_cause, C_ST);
    kret();
    retire(13'h0401, 1'b1);
    chk("R8 halt consumed", trap_req, 0);
    kret();
    retire(13'h0123, 1'b1);
    chk("R9 stray return harmless", trap_cause, C_BP);
    kret();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_regs();
    t_bp_hit();
    t_kernel_area();
    t_disabled();
    t_step();
    t_halt();
    t_coincide();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule